// File: doc/BRIEF.md
# Prioritised Reference Clock Selector

This block picks one working timing reference out of fourteen candidate input channels. Each channel has a fixed 4-bit identity code from 0001 to 1110. Each channel also carries a priority value that software can program, and a validity flag supplied by an upstream quality monitor. When a monitor flags a channel for too many pattern departures, that channel counts as invalid. The block keeps the preferred usable channel selected and moves away from the current one on its own when it fails.

A channel becomes a candidate only after it has stayed valid for a programmable number of monitor ticks. A revertive control input decides whether a better channel that becomes usable again takes over from a working current channel. When no channel can be used, the selected code reads 0000 and a holdover request tells the downstream loop to coast. Every change of selection raises a one-cycle strobe. The selected code can also be read back over the same small register bus that holds the priorities.

Top module: `ref_selector`

## Requirements
- R1: After reset the selected code is 0000, the holdover request is high, the switch strobe is low, and channel code c (1 to 14) holds priority c+1.
- R2: A bus write to address c (1 to 14) stores wdata[3:0] as the priority of channel code c. A read of address c returns that priority in rdata[3:0] with the upper bits zero. A read of address 0 returns the selected code in rdata[3:0]. Address 15 reads as zero, and writes to addresses 0 and 15 change nothing.
- R3: Among the qualified channels with a non-zero priority, the one with the smallest priority value is chosen. On equal priority the lower channel code wins.
- R4: A channel with priority 0 is never selected. Writing 0 to the current channel's priority forces a reselection.
- R5: When the current channel stops being qualified, the best remaining qualified channel is selected without any bus access. Input changes show up on the selected code two clock edges after they are applied.
- R6: With revertive high, a qualified channel with a strictly smaller priority value than the current one takes over.
- R7: With revertive low, a working current channel is kept even when a better channel is qualified.
- R8: A channel qualifies only after holdoff_ticks mon_tick pulses while its validity stays high. A drop of validity clears its progress, and a hold-off of 0 qualifies on the first valid cycle.
- R9: When no channel is qualified with a non-zero priority, the selected code becomes 0000 and holdover_req is high. holdover_req is high exactly when the selected code is 0000.
- R10: switch_strobe is high for exactly the one cycle in which the selected code takes a new value, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_valid | input | 14 | Per-channel validity from the monitors, bit i is channel code i+1 |
| mon_tick | input | 1 | Monitor tick pulse that advances hold-off counting |
| revertive | input | 1 | 1: switch back to a better channel; 0: stay on a working channel |
| holdoff_ticks | input | 8 | Ticks of continuous validity needed before a channel qualifies |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sel_code | output | 4 | Code of the selected channel, 0000 when none |
| switch_strobe | output | 1 | One-cycle pulse on every selection change |
| holdover_req | output | 1 | High while no reference is selected |

## Verification
A change on ch_valid or a priority write registers at the first rising edge. The selected code, the strobe and the holdover flag follow at the second edge. A hold-off run adds one edge per required tick before the qualifying edge. Bus reads are combinational and are checked one time step after the address settles. The bench drives inputs on falling edges and compares outputs on falling edges against a reference model that it advances on each rising edge, so each comparison sees exactly the state that results from the inputs of the previous cycle. Directed cases with fixed expected codes cover ties, disabled channels, revertive on and off, failover, the loss of every channel and hold-off counting, and a seeded random phase follows them.

// File: rtl/ref_sel_pkg.sv
// Shared helpers for the reference selector.
// Assumes: priority 0 means disabled, a smaller non-zero value is preferred.
package ref_sel_pkg;

    // True when candidate (ap, ac) is preferred over (bp, bc); bc==0 means no incumbent.
    function automatic logic prio_wins(input int ap, input int ac, input int bp, input int bc);
        if (ap == 0)
            return 1'b0;
        if (bc == 0)
            return 1'b1;
        if (ap < bp)
            return 1'b1;
        return (ap == bp) && (ac < bc);
    endfunction

endpackage

// File: rtl/ref_prio_regs.sv
// Priority register file and read mux.
// Assumes: address c in 1..NUM_CH maps to channel code c, address 0 reads status.
module ref_prio_regs #(
    parameter int NUM_CH = 14,
    parameter int PRIO_W = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CODE_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic [CODE_W-1:0]             status_code,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NUM_CH-1:0][PRIO_W-1:0] prio
);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
            localparam logic [PRIO_W-1:0] DEFAULT_PRIO = PRIO_W'(i + 2);
            // Holds one channel's priority, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio[i] <= DEFAULT_PRIO;
                else if (bus_we && (int'(bus_addr) == i + 1))
                    prio[i] <= bus_wdata[PRIO_W-1:0];
            end
        end
    endgenerate

    // Selects status or one priority for the read port.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0)
            bus_rdata[CODE_W-1:0] = status_code;
        else
            for (int i = 0; i < NUM_CH; i++)
                if (int'(bus_addr) == i + 1)
                    bus_rdata[PRIO_W-1:0] = prio[i];
    end

endmodule

// File: rtl/ref_qualify.sv
// Per-channel hold-off qualification.
// Assumes: validity may toggle any cycle; mon_tick is a single-cycle pulse.
module ref_qualify #(
    parameter int NUM_CH = 14,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_valid,
    input  logic              mon_tick,
    input  logic [HOLD_W-1:0] holdoff_ticks,
    output logic [NUM_CH-1:0] qual
);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic [HOLD_W-1:0] cnt;
            // Counts ticks of continuous validity and flags the channel when enough have passed.
            always_ff @(posedge clk) begin
                if (!rst_n || !ch_valid[i]) begin
                    cnt     <= '0;
                    qual[i] <= 1'b0;
                end else if (cnt >= holdoff_ticks) begin
                    qual[i] <= 1'b1;
                end else if (mon_tick) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ref_pick.sv
// Combinational search for the preferred qualified channel.
// Assumes: scan in ascending code order so ties keep the lower code.
module ref_pick #(
    parameter int NUM_CH = 14,
    parameter int PRIO_W = 4,
    parameter int CODE_W = 4
) (
    input  logic [NUM_CH-1:0]             qual,
    input  logic [NUM_CH-1:0][PRIO_W-1:0] prio,
    output logic [CODE_W-1:0]             best_code,
    output logic [PRIO_W-1:0]             best_prio
);
    import ref_sel_pkg::*;

    // Keeps the running winner across all channels.
    always_comb begin
        best_code = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (qual[i] && prio_wins(int'(prio[i]), i + 1, int'(best_prio), int'(best_code))) begin
                best_code = CODE_W'(i + 1);
                best_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/ref_selector.sv
// Top: keeps the preferred qualified reference selected, with revertive control.
// Assumes: outputs are registered; a cause seen at one edge shows on sel_code at the next.
module ref_selector #(
    parameter int NUM_CH = 14,
    parameter int PRIO_W = 4,
    parameter int HOLD_W = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_valid,
    input  logic              mon_tick,
    input  logic              revertive,
    input  logic [HOLD_W-1:0] holdoff_ticks,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CODE_W-1:0] sel_code,
    output logic              switch_strobe,
    output logic              holdover_req
);

    logic [NUM_CH-1:0][PRIO_W-1:0] prio;
    logic [NUM_CH-1:0]             qual_vec;
    logic [CODE_W-1:0]             best_code;
    logic [PRIO_W-1:0]             best_prio;
    logic [PRIO_W-1:0]             cur_prio;
    logic                          cur_ok;
    logic [CODE_W-1:0]             next_code;

    ref_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                    .DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .status_code(sel_code), .bus_rdata(bus_rdata),
        .prio(prio));

    ref_qualify #(.NUM_CH(NUM_CH), .HOLD_W(HOLD_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .mon_tick(mon_tick),
        .holdoff_ticks(holdoff_ticks), .qual(qual_vec));

    ref_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_pick (
        .qual(qual_vec), .prio(prio), .best_code(best_code), .best_prio(best_prio));

    // Checks whether the current channel is still usable.
    always_comb begin
        cur_ok   = 1'b0;
        cur_prio = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(sel_code) == i + 1) begin
                cur_prio = prio[i];
                cur_ok   = qual_vec[i] && (prio[i] != '0);
            end
        end
    end

    // Chooses failover, revert or hold.
    always_comb begin
        if (!cur_ok)
            next_code = best_code;
        else if (revertive && (best_code != '0) && (best_prio < cur_prio))
            next_code = best_code;
        else
            next_code = sel_code;
    end

    // Registers the selection, the strobe and the holdover flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_code      <= '0;
            switch_strobe <= 1'b0;
            holdover_req  <= 1'b1;
        end else begin
            sel_code      <= next_code;
            switch_strobe <= (next_code != sel_code);
            holdover_req  <= (next_code == '0);
        end
    end

endmodule

// File: rtl/ref_selector_chk.sv
// Assertion checker bound into ref_selector.
// Assumes: inputs are sampled on the rising clock; registered copies give the previous cycle.
module ref_selector_chk #(
    parameter int NUM_CH = 14,
    parameter int PRIO_W = 4,
    parameter int CODE_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             ch_valid,
    input logic [NUM_CH-1:0]             qual_vec,
    input logic [NUM_CH-1:0][PRIO_W-1:0] prio,
    input logic [CODE_W-1:0]             sel_code,
    input logic                          switch_strobe,
    input logic                          holdover_req
);
    logic [NUM_CH-1:0] qual_d, nz_d, valid_d, usable_d;

    // Keeps last cycle's qualification, non-zero priorities and validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_d  <= '0;
            nz_d    <= '0;
            valid_d <= '0;
        end else begin
            qual_d  <= qual_vec;
            valid_d <= ch_valid;
            for (int i = 0; i < NUM_CH; i++)
                nz_d[i] <= (prio[i] != '0);
        end
    end

    assign usable_d = qual_d & nz_d;

    a_r3_sel_was_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != '0) |-> qual_d[sel_code - 1'b1]);
    a_r4_sel_not_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != '0) |-> nz_d[sel_code - 1'b1]);
    a_r9_none_usable_holdover: assert property (@(posedge clk) disable iff (!rst_n)
        (usable_d == '0) |-> (sel_code == '0 && holdover_req));
    a_r9_holdover_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        holdover_req == (sel_code == '0));
    a_r10_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        switch_strobe |-> !$stable(sel_code));
    a_r10_quiet_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !switch_strobe |-> $stable(sel_code));
    a_r8_qual_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_vec & ~valid_d) == '0);

endmodule

bind ref_selector ref_selector_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .qual_vec(qual_vec), .prio(prio),
    .sel_code(sel_code), .switch_strobe(switch_strobe), .holdover_req(holdover_req));

// File: tb/tb_ref_selector.sv
module tb_ref_selector;
    localparam int CLK_PERIOD = 10;
    localparam int N = 14;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] ch_valid = '0;
    logic mon_tick = 0, revertive = 0;
    logic [7:0] holdoff_ticks = '0;
    logic [3:0] bus_addr = '0;
    logic bus_we = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] sel_code;
    logic switch_strobe, holdover_req;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    ref_selector dut (.clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .mon_tick(mon_tick),
        .revertive(revertive), .holdoff_ticks(holdoff_ticks), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_code(sel_code),
        .switch_strobe(switch_strobe), .holdover_req(holdover_req));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, written from the requirements
    int m_prio[N];
    int m_cnt[N];
    bit m_q[N];
    int m_sel;
    bit m_stb, m_hold;

    function automatic int best_of(output int bp);
        int bc = 0;
        bp = 0;
        for (int i = 0; i < N; i++)
            if (m_q[i] && m_prio[i] != 0 && (bc == 0 || m_prio[i] < bp)) begin
                bc = i + 1; bp = m_prio[i];
            end
        return bc;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_prio[i] = i + 2; m_cnt[i] = 0; m_q[i] = 0; end
            m_sel = 0; m_stb = 0; m_hold = 1;
        end else begin
            int bp, bc, nxt;
            bit ok;
            bc = best_of(bp);
            ok = (m_sel != 0) && m_q[m_sel-1] && m_prio[m_sel-1] != 0;
            if (!ok) nxt = bc;
            else if (revertive && bc != 0 && bp < m_prio[m_sel-1]) nxt = bc;
            else nxt = m_sel;
            m_stb = (nxt != m_sel); m_sel = nxt; m_hold = (nxt == 0);
            for (int i = 0; i < N; i++) begin
                if (!ch_valid[i]) begin m_cnt[i] = 0; m_q[i] = 0; end
                else if (m_cnt[i] >= int'(holdoff_ticks)) m_q[i] = 1;
                else if (mon_tick) m_cnt[i]++;
            end
            if (bus_we && bus_addr >= 1 && bus_addr <= 14)
                m_prio[bus_addr-1] = int'(bus_wdata[3:0]);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model on falling edges
    always @(negedge clk) if (rst_n && !done) begin
        check("R3 sel_code vs model", int'(sel_code), m_sel);
        check("R10 strobe vs model", int'(switch_strobe), int'(m_stb));
        check("R9 holdover vs model", int'(holdover_req), int'(m_hold));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_we = 1;
        cyc(1);
        bus_we = 0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        bus_addr = 4'(a);
        #1;
        check(req, int'(bus_rdata), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        check("R1 reset sel", int'(sel_code), 0);
        check("R1 reset holdover", int'(holdover_req), 1);
        check("R1 reset strobe", int'(switch_strobe), 0);
        for (int c = 1; c <= 14; c++) rd_check("R1 default prio", c, c + 1);
        rd_check("R2 addr15 reads zero", 15, 0);
        rd_check("R2 status reads code", 0, 0);
        // R2 writes to 0 and 15 ignored
        wr(0, 8'hFF); wr(15, 8'hFF);
        rd_check("R2 addr15 after write", 15, 0);
        rd_check("R2 status after write", 0, 0);
        // R3 codes 3 and 5 valid: priority 4 beats 6
        ch_valid = 14'b00000000010100;
        cyc(1);
        check("R5 two-edge latency not yet", int'(sel_code), 0);
        cyc(1);
        check("R3 prefers lower value", int'(sel_code), 3);
        check("R10 strobe on change", int'(switch_strobe), 1);
        cyc(1);
        check("R10 strobe one cycle", int'(switch_strobe), 0);
        rd_check("R2 status shows code", 0, 3);
        // R7 non-revertive keeps current
        wr(5, 1);
        rd_check("R2 prio readback", 5, 1);
        cyc(3);
        check("R7 stays on current", int'(sel_code), 3);
        // R6 revertive switches
        revertive = 1;
        cyc(2);
        check("R6 reverts to better", int'(sel_code), 5);
        // R4 disable current channel
        wr(5, 0);
        cyc(1);
        check("R4 disabled channel left", int'(sel_code), 3);
        // R3 tie: codes 6 and 9 at priority 3
        wr(5, 6); wr(6, 3); wr(9, 3);
        ch_valid = '0;
        cyc(3);
        check("R9 all lost sel", int'(sel_code), 0);
        check("R9 all lost holdover", int'(holdover_req), 1);
        ch_valid = 14'b00000100100000;
        cyc(2);
        check("R3 tie lower code", int'(sel_code), 6);
        // R5 failover
        ch_valid[5] = 0;
        cyc(2);
        check("R5 failover", int'(sel_code), 9);
        // R4 only remaining channel disabled
        wr(9, 0);
        cyc(1);
        check("R4 priority 0 never selected", int'(sel_code), 0);
        wr(9, 10);
        ch_valid = '0;
        cyc(2);
        // R8 hold-off of 3 ticks on code 2
        holdoff_ticks = 3;
        ch_valid[1] = 1;
        for (int t = 0; t < 2; t++) begin mon_tick = 1; cyc(1); mon_tick = 0; cyc(2); end
        check("R8 not qualified after 2 ticks", int'(sel_code), 0);
        ch_valid[1] = 0; cyc(1); ch_valid[1] = 1;
        mon_tick = 1; cyc(1); mon_tick = 0; cyc(3);
        check("R8 progress cleared by drop", int'(sel_code), 0);
        for (int t = 0; t < 2; t++) begin mon_tick = 1; cyc(1); mon_tick = 0; cyc(1); end
        cyc(1);
        check("R8 qualified after 3 ticks", int'(sel_code), 2);
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            int r = $urandom_range(0, 99);
            mon_tick = ($urandom_range(0, 3) == 0);
            if (r < 8) ch_valid[$urandom_range(0, N-1)] ^= 1'b1;
            if (r >= 90) begin
                bus_addr = 4'($urandom_range(0, 15));
                bus_wdata = 8'($urandom_range(0, 255));
                bus_we = 1;
            end else bus_we = 0;
            if (r == 50) revertive = ~revertive;
            if (r == 51) holdoff_ticks = 8'($urandom_range(0, 3));
            cyc(1);
        end
        bus_we = 0;
        cyc(1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule